// File: doc/BRIEF.md
# Decimal Up/Down Counter with Split Count Strobes

This block is a four-bit decimal counter that steps through 0 to 9 in 8421 weighting. Instead of one clock plus a direction pin it has two count strobes: a rising edge on the up strobe adds one, and a rising edge on the down strobe subtracts one. Each edge counts only while the other strobe rests high. Both strobes are sampled on one system clock, and an edge is found by comparing each sampled level with its value one clock earlier.

Two controls act at once, without waiting for a clock edge. An active-high clear forces the output to zero and wins over everything. An active-low load shows the four preset inputs on the output for as long as it is held. The active-low carry and borrow outputs pulse low only while the counter sits at its terminal value and the matching strobe is low. Their rising edge therefore falls on the same sample as the strobe edge that makes the counter wrap, so several stages chain into a multi-digit counter with no glue logic between them.

Top module: `bcd_updown_ctr`

## Requirements
- R1: While `mr_i` is 1, `cnt_o` reads 0 at once, without a clock edge, whatever the strobes and `load_n_i` do. The count register is 0 after `mr_i` falls.
- R2: While `mr_i` is 0 and `load_n_i` is 0, `cnt_o` shows `preset_i` at once, and the strobes have no effect. After `load_n_i` rises, the last preset value is kept.
- R3: A rising edge of `up_stb_i`, seen while `dn_stb_i` is 1, raises the count by one at the clock edge where the high level is first sampled after a low sample. With `SYNC_STAGES` at 0 there is no extra latency.
- R4: A rising edge of `dn_stb_i`, seen while `up_stb_i` is 1, lowers the count by one with the same timing as R3.
- R5: The count holds when there is no strobe edge, when both strobes rise on the same sample, or when one strobe rises while the other is 0.
- R6: Counting up from 9 gives 0. Counting down from 0 gives 9.
- R7: A loaded value from 10 to 15 counts up modulo 16 (15 gives 0) and counts down by one (10 gives 9).
- R8: `carry_n_o` is 0 exactly when `cnt_o` is 9 and `up_stb_i` is 0.
- R9: `borrow_n_o` is 0 exactly when `cnt_o` is 0 and `dn_stb_i` is 0.
- R10: A strobe edge that occurs while `mr_i` is 1 or `load_n_i` is 0 does not cause a count after the control is released.
- R11: In a chain where each stage's `carry_n_o` drives the next stage's `up_stb_i` and its `borrow_n_o` drives the next `dn_stb_i`, two stages count decimally from 00 to 99 in both directions and wrap at the ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| mr_i | input | 1 | Asynchronous clear, active high |
| load_n_i | input | 1 | Asynchronous preset load, active low |
| preset_i | input | 4 | Value used while loading |
| up_stb_i | input | 1 | Count-up strobe, counts on its rising edge |
| dn_stb_i | input | 1 | Count-down strobe, counts on its rising edge |
| cnt_o | output | 4 | Current count, 8421 code |
| carry_n_o | output | 1 | Terminal-count-up indication, active low |
| borrow_n_o | output | 1 | Terminal-count-down indication, active low |

## Verification
The hardest case to reach is the carry or borrow wrap through a second stage. That stage sees only the first stage's terminal outputs, and the tens digit changes only on the one sample where the first stage's strobe edge and its own arrive together. The bench chains two instances and drives more than a hundred up pulses and a run of down pulses, so the chain wraps at 99 and at 00 in both directions. Strobe edges hidden under clear or load, and loaded values from 10 to 15, are produced by directed sequences. A long random run with rare clear and load pulses mixes all of these against a cycle model.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;

   // Action chosen by the count core for one clock
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2
   } step_e;

   // Which asynchronous control currently owns the output
   typedef enum logic [1:0] {
      OVR_NONE  = 2'd0,
      OVR_CLEAR = 2'd1,
      OVR_LOAD  = 2'd2
   } ovr_e;

endpackage

// File: rtl/bcd_strobe_edge.sv
module bcd_strobe_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic clr,
   input  logic stb_i,
   output logic lvl_o,
   output logic rise_o
);

   logic prev_q;

   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("SYNC_STAGES must not be negative");
   end

   // Variant choice: direct sampling or a synchronizer chain in front
   if (SYNC_STAGES == 0) begin : g_direct
      assign lvl_o = stb_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or posedge clr) begin
         if (clr) sync_q <= '1;
         else     sync_q <= {sync_q[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0:0], stb_i} & {SYNC_STAGES{1'b1}};
      end
      assign lvl_o = sync_q[SYNC_STAGES-1];
   end

   // Idle level of a strobe is high, so the history resets to 1
   always_ff @(posedge clk or posedge clr) begin
      if (clr) prev_q <= 1'b1;
      else     prev_q <= lvl_o;
   end

   assign rise_o = lvl_o & ~prev_q;

   AST_EDGE_ONE_SAMPLE: assert property (@(posedge clk) disable iff (clr)
      rise_o |=> !rise_o); // R3

endmodule

// File: rtl/bcd_count_core.sv
module bcd_count_core
   import bcd_ctr_pkg::*;
#(
   parameter int W    = 4,
   parameter int LAST = 9
) (
   input  logic         clk,
   input  logic         clr,
   input  logic         load_n,
   input  logic [W-1:0] preset,
   input  logic         up_rise,
   input  logic         dn_rise,
   input  logic         up_lvl,
   input  logic         dn_lvl,
   output logic [W-1:0] cnt_o
);

   localparam logic [W-1:0] LAST_V = W'(LAST);
   localparam logic [W-1:0] ZERO_V = '0;
   localparam logic [W-1:0] ONE_V  = W'(1);

   step_e        step;
   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_inc;
   logic [W-1:0] cnt_dec;

   // One strobe must rise while the other rests high
   always_comb begin
      step = STEP_HOLD;
      if (up_rise && dn_lvl && !dn_rise)      step = STEP_UP;
      else if (dn_rise && up_lvl && !up_rise) step = STEP_DOWN;
   end

   // Upward: terminal wraps to zero, others (including 10..15) step modulo 2**W
   assign cnt_inc = (cnt_q == LAST_V) ? ZERO_V : cnt_q + ONE_V;
   // Downward: zero wraps to terminal, others step down
   assign cnt_dec = (cnt_q == ZERO_V) ? LAST_V : cnt_q - ONE_V;

   always_ff @(posedge clk or posedge clr) begin
      if (clr)          cnt_q <= ZERO_V;
      else if (!load_n) cnt_q <= preset;
      else begin
         case (step)
            STEP_UP:   cnt_q <= cnt_inc;
            STEP_DOWN: cnt_q <= cnt_dec;
            default:   cnt_q <= cnt_q;
         endcase
      end
   end

   assign cnt_o = cnt_q;

   AST_WRAP_UP: assert property (@(posedge clk) disable iff (clr)
      (load_n && up_rise && dn_lvl && !dn_rise && cnt_q == LAST_V) |=> (cnt_q == ZERO_V)); // R6
   AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (clr)
      (load_n && dn_rise && up_lvl && !up_rise && cnt_q == ZERO_V) |=> (cnt_q == LAST_V)); // R6
   AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (clr)
      (load_n && !up_rise && !dn_rise) |=> $stable(cnt_q)); // R5
   AST_HOLD_BOTH_EDGES: assert property (@(posedge clk) disable iff (clr)
      (load_n && up_rise && dn_rise) |=> $stable(cnt_q)); // R5
   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (clr)
      !load_n |=> (cnt_q == $past(preset))); // R2

endmodule

// File: rtl/bcd_term_decode.sv
module bcd_term_decode #(
   parameter int W    = 4,
   parameter int LAST = 9
) (
   input  logic [W-1:0] cnt_i,
   input  logic         up_lvl,
   input  logic         dn_lvl,
   output logic         carry_n_o,
   output logic         borrow_n_o
);

   localparam logic [W-1:0] LAST_V = W'(LAST);

   logic at_top;
   logic at_bottom;

   assign at_top    = (cnt_i == LAST_V);
   assign at_bottom = (cnt_i == '0);

   // Low only while the strobe is low, so the strobe's own rise lifts it
   assign carry_n_o  = ~(at_top & ~up_lvl);
   assign borrow_n_o = ~(at_bottom & ~dn_lvl);

   always_comb begin
      AST_CARRY_NEEDS_TOP: assert (carry_n_o || at_top); // R8
      AST_BORROW_NEEDS_ZERO: assert (borrow_n_o || at_bottom); // R9
   end

endmodule

// File: rtl/bcd_updown_ctr.sv
module bcd_updown_ctr
   import bcd_ctr_pkg::*;
#(
   parameter int W           = 4,
   parameter int LAST        = 9,
   parameter int SYNC_STAGES = 0
) (
   input  logic         clk,
   input  logic         mr_i,
   input  logic         load_n_i,
   input  logic [W-1:0] preset_i,
   input  logic         up_stb_i,
   input  logic         dn_stb_i,
   output logic [W-1:0] cnt_o,
   output logic         carry_n_o,
   output logic         borrow_n_o
);

   if (W < 2) begin : g_bad_w
      $error("W must be at least 2");
   end
   if (LAST < 1 || LAST >= (1 << W)) begin : g_bad_last
      $error("LAST must lie in 1 .. 2**W-1");
   end

   logic         up_lvl, up_rise;
   logic         dn_lvl, dn_rise;
   logic [W-1:0] cnt_q;
   ovr_e         ovr;

   bcd_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_up_edge (
      .clk    (clk),
      .clr    (mr_i),
      .stb_i  (up_stb_i),
      .lvl_o  (up_lvl),
      .rise_o (up_rise)
   );

   bcd_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_dn_edge (
      .clk    (clk),
      .clr    (mr_i),
      .stb_i  (dn_stb_i),
      .lvl_o  (dn_lvl),
      .rise_o (dn_rise)
   );

   bcd_count_core #(.W(W), .LAST(LAST)) u_core (
      .clk     (clk),
      .clr     (mr_i),
      .load_n  (load_n_i),
      .preset  (preset_i),
      .up_rise (up_rise),
      .dn_rise (dn_rise),
      .up_lvl  (up_lvl),
      .dn_lvl  (dn_lvl),
      .cnt_o   (cnt_q)
   );

   // Clear beats load; both act on the output without a clock
   always_comb begin
      if (mr_i)           ovr = OVR_CLEAR;
      else if (!load_n_i) ovr = OVR_LOAD;
      else                ovr = OVR_NONE;
   end

   always_comb begin
      case (ovr)
         OVR_CLEAR: cnt_o = '0;
         OVR_LOAD:  cnt_o = preset_i;
         default:   cnt_o = cnt_q;
      endcase
   end

   bcd_term_decode #(.W(W), .LAST(LAST)) u_term (
      .cnt_i      (cnt_o),
      .up_lvl     (up_lvl),
      .dn_lvl     (dn_lvl),
      .carry_n_o  (carry_n_o),
      .borrow_n_o (borrow_n_o)
   );

   AST_CLEAR_ZERO: assert property (@(posedge clk)
      mr_i |-> (cnt_o == '0)); // R1
   AST_CLEAR_HOLDS_REG: assert property (@(posedge clk) disable iff (mr_i)
      $past(mr_i) |-> (cnt_q == '0)); // R1
   AST_LOAD_SHOWS: assert property (@(posedge clk)
      (!mr_i && !load_n_i) |-> (cnt_o == preset_i)); // R2
   AST_NO_COUNT_AFTER_LOAD: assert property (@(posedge clk) disable iff (mr_i)
      (!load_n_i && up_lvl && dn_lvl) ##1 (load_n_i && up_lvl && dn_lvl) |=> $stable(cnt_q)); // R10

endmodule

// File: tb/bcd_updown_ctr_tb.sv
module bcd_updown_ctr_tb;

   logic       clk = 1'b0;
   always #4 clk = ~clk;

   logic       mr, load_n, up, dn;
   logic [3:0] pre;
   logic [3:0] q;
   logic       carry_n, borrow_n;

   logic       c_mr, c_up, c_dn;
   logic [3:0] lo_q, hi_q;
   logic       lo_c, lo_b, hi_c, hi_b;

   int         nchk = 0;
   int         nerr = 0;
   bit         done = 1'b0;

   logic [3:0] m_cnt;
   logic       m_pu, m_pd;

   bcd_updown_ctr u_dut (
      .clk(clk), .mr_i(mr), .load_n_i(load_n), .preset_i(pre),
      .up_stb_i(up), .dn_stb_i(dn),
      .cnt_o(q), .carry_n_o(carry_n), .borrow_n_o(borrow_n)
   );

   bcd_updown_ctr u_lo (
      .clk(clk), .mr_i(c_mr), .load_n_i(1'b1), .preset_i(4'd0),
      .up_stb_i(c_up), .dn_stb_i(c_dn),
      .cnt_o(lo_q), .carry_n_o(lo_c), .borrow_n_o(lo_b)
   );

   bcd_updown_ctr u_hi (
      .clk(clk), .mr_i(c_mr), .load_n_i(1'b1), .preset_i(4'd0),
      .up_stb_i(lo_c), .dn_stb_i(lo_b),
      .cnt_o(hi_q), .carry_n_o(hi_c), .borrow_n_o(hi_b)
   );

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [3:0] exp_q();
      if (mr)           return 4'd0;
      else if (!load_n) return pre;
      return m_cnt;
   endfunction

   task automatic verify(input string req);
      logic [3:0] e;
      e = exp_q();
      chk(req, int'(q), int'(e));
      chk({req, " R8 carry"}, int'(carry_n), int'(!(e == 4'd9 && !up)));
      chk({req, " R9 borrow"}, int'(borrow_n), int'(!(e == 4'd0 && !dn)));
   endtask

   // Reference step at a clock edge, from the requirements
   task automatic model_edge();
      logic ru, rd;
      if (mr) begin
         m_cnt = 4'd0; m_pu = 1'b1; m_pd = 1'b1;
      end else begin
         ru = up & ~m_pu;
         rd = dn & ~m_pd;
         if (!load_n)                m_cnt = pre;
         else if (ru && dn && !rd)   m_cnt = (m_cnt == 4'd9) ? 4'd0 : m_cnt + 4'd1;
         else if (rd && up && !ru)   m_cnt = (m_cnt == 4'd0) ? 4'd9 : m_cnt - 4'd1;
         m_pu = up;
         m_pd = dn;
      end
   endtask

   task automatic cyc(input string req);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      verify(req);
   endtask

   task automatic load(input logic [3:0] v);
      load_n = 1'b0; pre = v;
      #1 verify("R2 async load");
      cyc("R2");
      load_n = 1'b1;
      cyc("R2 kept");
   endtask

   task automatic up_pulse(input string req);
      up = 1'b0; cyc(req);
      up = 1'b1; cyc(req);
   endtask

   task automatic dn_pulse(input string req);
      dn = 1'b0; cyc(req);
      dn = 1'b1; cyc(req);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog expired at %0t", $time);
         summary();
         $finish;
      end
   end

   initial begin
      int cval;
      void'($urandom(32'd20240611));
      mr = 1'b1; load_n = 1'b1; up = 1'b1; dn = 1'b1; pre = 4'd0;
      c_mr = 1'b1; c_up = 1'b1; c_dn = 1'b1;
      m_cnt = 4'd0; m_pu = 1'b1; m_pd = 1'b1;
      @(negedge clk);
      up = 1'b0; dn = 1'b0; load_n = 1'b0; pre = 4'd6;
      cyc("R1 clear wins");
      up = 1'b1; dn = 1'b1; load_n = 1'b1;
      cyc("R1");
      mr = 1'b0; c_mr = 1'b0;
      cyc("R1 after release");

      // R3 / R6 / R8
      load(4'd8);
      up_pulse("R3 up 8->9");
      up = 1'b0; cyc("R8 carry low at 9");
      up = 1'b1; cyc("R6 up 9->0");
      // R9 / R4 / R6
      dn = 1'b0; cyc("R9 borrow low at 0");
      dn = 1'b1; cyc("R6 down 0->9");
      dn_pulse("R4 down 9->8");

      // R5: other strobe low, then both rising together
      up = 1'b0; dn = 1'b0; cyc("R5 both low");
      up = 1'b1; cyc("R5 up edge with down low");
      dn = 1'b1; cyc("R5 down edge");
      up = 1'b0; dn = 1'b0; cyc("R5");
      up = 1'b1; dn = 1'b1; cyc("R5 both edges");
      cyc("R5 idle");

      // R7: codes above nine
      load(4'd15); up_pulse("R7 15 up");
      load(4'd10); dn_pulse("R7 10 down");
      load(4'd12); up_pulse("R7 12 up");

      // R10: edges hidden under clear and load
      load(4'd3);
      mr = 1'b1; up = 1'b0; cyc("R10 under clear");
      up = 1'b1; cyc("R10 under clear");
      mr = 1'b0; cyc("R10 after clear");
      cyc("R10 after clear");
      load_n = 1'b0; pre = 4'd5; dn = 1'b0; cyc("R10 under load");
      dn = 1'b1; cyc("R10 under load");
      load_n = 1'b1; cyc("R10 after load");
      cyc("R10 after load");

      // R1: clear mid-cycle acts without a clock edge
      mr = 1'b1;
      #1 verify("R1 async clear");
      cyc("R1");
      mr = 1'b0; cyc("R1");

      // Random mix
      for (int i = 0; i < 3000; i++) begin
         mr     = ($urandom % 64) == 0;
         load_n = ($urandom % 24) != 0;
         up     = ($urandom % 3) != 0;
         dn     = ($urandom % 3) != 0;
         pre    = 4'($urandom);
         cyc("R5 random");
      end
      mr = 1'b0; load_n = 1'b1; up = 1'b1; dn = 1'b1;
      cyc("R5");

      // R11: two chained stages
      cval = 0;
      for (int i = 0; i < 125; i++) begin
         c_up = 1'b0; @(negedge clk);
         c_up = 1'b1; @(negedge clk);
         cval = (cval + 1) % 100;
         chk("R11 cascade up", int'(hi_q) * 10 + int'(lo_q), cval);
      end
      for (int i = 0; i < 60; i++) begin
         c_dn = 1'b0; @(negedge clk);
         c_dn = 1'b1; @(negedge clk);
         cval = (cval + 99) % 100;
         chk("R11 cascade down", int'(hi_q) * 10 + int'(lo_q), cval);
      end
      chk("R11 upper carry idle", int'(hi_c), 1);
      chk("R11 upper borrow idle", int'(hi_b), 1);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule